// File: doc/BRIEF.md
# Subcarrier Edge-Counting Bit Receiver

This block takes a card's answer off a single digital line that a hysteresis comparator drives from the demodulated field. The answer frame has no start mark, no stop mark and no length field, so the controller tells the block how many bits to expect. The controller pulses `start` at the instant its own outgoing frame ends. The block then waits a fixed number of timebase ticks and cuts the following time into equal bit windows. In each window it counts the level changes on the synchronized input. A window whose count falls strictly inside a set band holds the subcarrier and reads as 1. Any other count reads as 0.

When decryption is on, the block drives a one-cycle advance strobe to an external keystream generator during the quiet wait before the first window. It first skips a fixed number of keystream steps. It then samples one keystream bit for each expected data bit and advances after each sample, which gives a mask. Each received 1 toggles the matching mask bit. When decryption is off, the mask is zero and the received bits pass through unchanged. The word is built least significant bit first. When the last window closes, the block presents the word and the bit count with a one-cycle valid pulse. In the same cycle it pulses a clear that resynchronizes the shared bit timer for the next exchange.

Top module: `edge_bit_rx`

## Requirements
- R1: After reset, `valid`, `timer_clr` and `ks_step` are 0, and `data` and `nbits` are all zeros.
- R2: The bit count used and reported on `nbits` is `req_bits` clamped to MAX_BITS (16). A request of 0 gives an empty frame with `data` = 0.
- R3: A window decodes as 1 when its input-change count is above EDGE_LO (20) and below EDGE_HI (60). Counts of exactly 20 or exactly 60 decode as 0, and counts of 21 and 59 decode as 1.
- R4: The bit decoded in window i (i = 0 for the first window) lands in `data` bit i. Bits at positions n and above are 0. `data` changes only in a cycle where `valid` is 1.
- R5: With `decrypt` = 1 at `start`, `ks_step` pulses exactly 2 + n cycles, all before the first window. Mask bit i is the `ks_bit` value seen on the (3+i)-th pulse, and `data` = mask XOR decoded bits.
- R6: With `decrypt` = 0 at `start`, `ks_step` stays 0 for the whole frame and `data` equals the decoded bits.
- R7: Only cycles with `tick` = 1 advance time. The first window opens WAIT_TICKS (490) ticks after `start`, and each window lasts WIN_TICKS (150) ticks, so `valid` rises about (490 + 150·n) ticks after `start`.
- R8: `valid` is a single-cycle pulse, and `timer_clr` pulses in the same cycle.
- R9: A `start` pulse while a frame is in progress is ignored. The running frame completes with its original count, mode and timing.
- R10: The per-window change counter saturates at its maximum (63) and does not wrap. A window with 90 changes therefore decodes as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable, one per bit-timer tick |
| start | input | 1 | One-cycle pulse at the end of the outgoing reader frame |
| decrypt | input | 1 | Remove keystream from the received bits |
| req_bits | input | REQ_W (8) | Number of bits expected |
| rx_in | input | 1 | Asynchronous comparator output |
| ks_bit | input | 1 | Current keystream bit |
| ks_step | output | 1 | Advance the keystream generator by one step |
| data | output | MAX_BITS (16) | Received word, least significant bit first |
| valid | output | 1 | One-cycle pulse: `data` and `nbits` are updated |
| nbits | output | NB_W (5) | Bit count of the last frame |
| timer_clr | output | 1 | One-cycle pulse that restarts the shared bit timer |

## Verification
Results are due a fixed number of ticks after `start`: about 490 + 150·n ticks, plus one cycle for the output register. The bench counts falling clock edges from the `start` pulse and accepts `valid` only within a few cycles of that count. It samples `data`, `nbits` and `timer_clr` on that same edge, and it confirms on the next edge that `valid` has dropped. Input changes are placed well inside each window, away from both window edges, so the synchronizer delay and the tick phase cannot move a change into a neighbouring window. Keystream pulses are counted on rising edges over the whole frame and compared with 2 + n or with 0.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KS_ADV,
        ST_KS_GET,
        ST_WAIT,
        ST_WIN,
        ST_DONE
    } ebr_state_e;

endpackage

// File: rtl/ebr_sync.sv
// Synchronizes the comparator line and flags a level change.
module ebr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic change
);
    localparam int TOT = STAGES + 1;

    typedef struct packed {
        logic [TOT-1:0] sh;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.sh = {r_q.sh[TOT-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign change = r_q.sh[TOT-1] ^ r_q.sh[TOT-2];
endmodule

// File: rtl/ebr_edge_cnt.sv
// Saturating per-window change counter.
module ebr_edge_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nx
);
    localparam logic [CNT_W-1:0] SAT = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t r_d, r_q;

    always_comb begin
        if (r_q.cnt == SAT) count_nx = SAT;
        else                count_nx = r_q.cnt + CNT_W'(inc);
        r_d     = r_q;
        r_d.cnt = clr ? '0 : count_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count_q = r_q.cnt;
endmodule

// File: rtl/ebr_band.sv
// Decides 1 when a count lies strictly between the band limits.
module ebr_band #(
    parameter int CNT_W   = 6,
    parameter int EDGE_LO = 20,
    parameter int EDGE_HI = 60
) (
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(EDGE_LO);
    localparam logic [CNT_W-1:0] HI = CNT_W'(EDGE_HI);

    always_comb hit = (count > LO) && (count < HI);
endmodule

// File: rtl/edge_bit_rx.sv
module edge_bit_rx
    import ebr_pkg::*;
#(
    parameter int MAX_BITS   = 16,
    parameter int REQ_W      = 8,
    parameter int WAIT_TICKS = 490,
    parameter int WIN_TICKS  = 150,
    parameter int EDGE_LO    = 20,
    parameter int EDGE_HI    = 60,
    parameter int ADV_STEPS  = 2,
    parameter int SYNC_STG   = 2,
    localparam int NB_W      = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                start,
    input  logic                decrypt,
    input  logic [REQ_W-1:0]    req_bits,
    input  logic                rx_in,
    input  logic                ks_bit,
    output logic                ks_step,
    output logic [MAX_BITS-1:0] data,
    output logic                valid,
    output logic [NB_W-1:0]     nbits,
    output logic                timer_clr
);
    localparam int CNT_W  = $clog2(EDGE_HI + 1);
    localparam int WAIT_W = $clog2(WAIT_TICKS);
    localparam int WIN_W  = $clog2(WIN_TICKS);
    localparam int ADV_W  = $clog2(ADV_STEPS + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_TICKS - 1);
    localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_TICKS - 1);
    localparam logic [ADV_W-1:0]  ADV_LAST  = ADV_W'(ADV_STEPS - 1);

    typedef struct packed {
        ebr_state_e          st;
        logic [NB_W-1:0]     n;
        logic [NB_W-1:0]     idx;
        logic [ADV_W-1:0]    adv;
        logic [WAIT_W-1:0]   wcnt;
        logic [WIN_W-1:0]    bcnt;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] data;
        logic [NB_W-1:0]     nbits;
        logic                valid;
        logic                clr;
    } rx_t;

    rx_t r_d, r_q;

    logic             edge_seen;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             bit_hit;
    logic             in_win;
    logic             win_end;
    logic [NB_W-1:0]  n_req;

    ebr_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (rx_in),
        .change (edge_seen)
    );

    ebr_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (edge_seen),
        .count_q  (cnt_q),
        .count_nx (cnt_nx)
    );

    ebr_band #(.CNT_W(CNT_W), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)) u_band (
        .count (cnt_nx),
        .hit   (bit_hit)
    );

    assign in_win  = (r_q.st == ST_WIN);
    assign win_end = in_win && tick && (r_q.bcnt == WIN_LAST);
    assign cnt_clr = !in_win || win_end;
    assign n_req   = (req_bits > REQ_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : NB_W'(req_bits);
    assign ks_step = (r_q.st == ST_KS_ADV) || (r_q.st == ST_KS_GET);

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.clr   = 1'b0;

        // wait counter runs from start until the first window opens
        if ((r_q.st == ST_KS_ADV || r_q.st == ST_KS_GET || r_q.st == ST_WAIT)
            && tick && (r_q.wcnt != WAIT_LAST))
            r_d.wcnt = r_q.wcnt + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.n    = n_req;
                    r_d.idx  = '0;
                    r_d.adv  = '0;
                    r_d.wcnt = '0;
                    r_d.acc  = '0;
                    r_d.st   = decrypt ? ST_KS_ADV : ST_WAIT;
                end
            end
            ST_KS_ADV: begin
                r_d.adv = r_q.adv + 1'b1;
                if (r_q.adv == ADV_LAST)
                    r_d.st = (r_q.n == '0) ? ST_WAIT : ST_KS_GET;
            end
            ST_KS_GET: begin
                r_d.acc = r_q.acc | ({{(MAX_BITS-1){1'b0}}, ks_bit} << r_q.idx);
                r_d.idx = r_q.idx + 1'b1;
                if (r_q.idx + 1'b1 == r_q.n) begin
                    r_d.idx = '0;
                    r_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tick && (r_q.wcnt == WAIT_LAST)) begin
                    r_d.bcnt = '0;
                    r_d.st   = (r_q.n == '0) ? ST_DONE : ST_WIN;
                end
            end
            ST_WIN: begin
                if (tick) begin
                    if (r_q.bcnt == WIN_LAST) begin
                        r_d.bcnt = '0;
                        r_d.acc  = r_q.acc ^ ({{(MAX_BITS-1){1'b0}}, bit_hit} << r_q.idx);
                        r_d.idx  = r_q.idx + 1'b1;
                        if (r_q.idx + 1'b1 == r_q.n) r_d.st = ST_DONE;
                    end else begin
                        r_d.bcnt = r_q.bcnt + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.data  = r_q.acc;
                r_d.nbits = r_q.n;
                r_d.valid = 1'b1;
                r_d.clr   = 1'b1;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign data      = r_q.data;
    assign valid     = r_q.valid;
    assign nbits     = r_q.nbits;
    assign timer_clr = r_q.clr;
endmodule

// File: rtl/ebr_chk.sv
module ebr_chk #(
    parameter int MAX_BITS = 16,
    parameter int NB_W     = 5,
    parameter int CNT_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid,
    input logic                timer_clr,
    input logic [MAX_BITS-1:0] data,
    input logic [NB_W-1:0]     nbits,
    input logic                ks_step,
    input logic                in_win,
    input logic                cnt_clr,
    input logic [CNT_W-1:0]    cnt_q
);
    localparam logic [CNT_W-1:0] SAT = '1;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8
    clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_clr |-> valid);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(data));

    // R2
    nbits_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nbits <= NB_W'(MAX_BITS));

    // R5
    ks_before_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> !ks_step);

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SAT && !cnt_clr) |=> (cnt_q == SAT));
endmodule

bind edge_bit_rx ebr_chk #(
    .MAX_BITS (MAX_BITS),
    .NB_W     (NB_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .timer_clr (timer_clr),
    .data      (data),
    .nbits     (nbits),
    .ks_step   (ks_step),
    .in_win    (in_win),
    .cnt_clr   (cnt_clr),
    .cnt_q     (cnt_q)
);

// File: tb/sim_edge_bit_rx.sv
`timescale 1ns/1ps
module sim_edge_bit_rx;
    localparam int MAXB = 16;
    localparam int WAITT = 490;
    localparam int WINT = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic        decrypt = 1'b0;
    logic [7:0]  req_bits = '0;
    logic        rx_in = 1'b0;
    logic        ks_bit;
    logic        ks_step;
    logic [15:0] data;
    logic        valid;
    logic [4:0]  nbits;
    logic        timer_clr;

    int checks = 0;
    int errors = 0;
    int tp = 1;
    int phase = 0;
    int ks_pulses = 0;
    int cycles = 0;
    logic [6:0] lfsr = 7'h5A;

    always #2.5 clk = ~clk;

    edge_bit_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .decrypt(decrypt),
        .req_bits(req_bits), .rx_in(rx_in), .ks_bit(ks_bit), .ks_step(ks_step),
        .data(data), .valid(valid), .nbits(nbits), .timer_clr(timer_clr)
    );

    function automatic logic [6:0] lstep(input logic [6:0] s);
        return {s[5:0], s[6] ^ s[5]};
    endfunction

    assign ks_bit = lfsr[0];

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ks_step) begin
            lfsr <= lstep(lfsr);
            ks_pulses <= ks_pulses + 1;
        end
    end

    always @(negedge clk) begin
        phase = phase + 1;
        tick = (tp == 1) ? 1'b1 : (phase % tp == 0);
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int edge_count(input int f, input int i);
        int tbl [8] = '{0, 20, 21, 42, 59, 60, 90, 5};
        return tbl[(i * 3 + f) % 8];
    endfunction

    task automatic run_frame(input int f, input int req, input bit dec,
                             input int tper, input bit glitch);
        int n = (req > MAXB) ? MAXB : req;
        int exp_data = 0;
        int mask = 0;
        int k = 0;
        int vk = -1;
        int vdata = 0, vn = 0, vclr = 0, vafter = 1;
        logic [6:0] s;
        tp = tper;
        s = lfsr;
        if (dec) begin
            s = lstep(lstep(s));
            for (int b = 0; b < n; b++) begin
                mask |= int'(s[0]) << b;
                s = lstep(s);
            end
        end
        for (int b = 0; b < n; b++) begin
            int c = edge_count(f, b);
            if (c > 20 && c < 60) exp_data ^= (1 << b);
        end
        exp_data ^= mask;
        ks_pulses = 0;
        @(negedge clk);
        start = 1'b1; decrypt = dec; req_bits = 8'(req);
        @(negedge clk);
        start = 1'b0; decrypt = ~dec; req_bits = 8'd3;
        k = 1;
        while (k < (WAITT + WINT * n) * tp + 12) begin
            int rel = k - WAITT * tp;
            if (glitch && k == 600) start = 1'b1;
            else start = 1'b0;
            if (rel >= 0 && n > 0) begin
                int w = rel / (WINT * tp);
                int o = rel % (WINT * tp);
                if (w < n && o >= 20 && o < 20 + edge_count(f, w)) rx_in = ~rx_in;
            end
            if (valid && vk < 0) begin
                vk = k; vdata = data; vn = nbits; vclr = timer_clr;
            end else if (vk >= 0 && k == vk + 1) begin
                vafter = valid;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check($sformatf("R7 valid time f%0d", f), (vk >= (WAITT + WINT * n) * tp - 3 &&
              vk <= (WAITT + WINT * n) * tp + 4) ? 1 : 0, 1);
        check($sformatf("R4 data f%0d", f), vdata, exp_data);
        check($sformatf("R2 nbits f%0d", f), vn, n);
        check($sformatf("R8 clr f%0d", f), vclr, 1);
        check($sformatf("R8 pulse f%0d", f), int'(vafter), 0);
        if (dec) check($sformatf("R5 ks pulses f%0d", f), ks_pulses, 2 + n);
        else     check($sformatf("R6 ks pulses f%0d", f), ks_pulses, 0);
        if (glitch) check($sformatf("R9 restart ignored f%0d", f), vn, n);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(valid), 0);
        check("R1 data", int'(data), 0);
        check("R1 nbits", int'(nbits), 0);
        check("R1 ks_step", int'(ks_step), 0);
        check("R1 timer_clr", int'(timer_clr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R3 band edges and R10 saturation (90 changes) appear in every long frame
        run_frame(0, 16, 1'b1, 1, 1'b0);
        run_frame(1, 16, 1'b0, 1, 1'b0);
        run_frame(2, 1, 1'b1, 1, 1'b0);
        run_frame(3, 0, 1'b1, 1, 1'b0);
        run_frame(4, 5, 1'b0, 2, 1'b0);
        run_frame(5, 20, 1'b1, 1, 1'b0);
        run_frame(6, 255, 1'b0, 1, 1'b0);
        run_frame(7, 7, 1'b1, 1, 1'b1);
        run_frame(2, 3, 1'b1, 2, 1'b0);
        run_frame(4, 16, 1'b1, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule